// File: doc/BRIEF.md
# Dual-Plane Flash Status Read Generator

This block forms the data word a host reads from a two-plane flash array while an internally timed program or erase is under way. It overlays three status bits on the array data: a polling bit (bit 7), a busy toggle bit (bit 6) and a suspend toggle bit (bit 2). A read that lands on the plane carrying the running operation returns status. A read from the other plane returns plain array data. While an erase is held in suspend, only the sector under erase reports status, so the host can read or program the rest of the array around it.

The operation controller supplies the current operation state, the busy plane, the sector under erase and the polled bit of the last word loaded for programming. The read path supplies the read plane, the read sector and the raw array word. A read is active while both active-low chip enable and output enable are low. The toggle bits advance once at the start of each such read and never advance on clock edges alone. A registered ready output is low while a program or erase is actively running, and it can drive an open-drain pin.

Top module: `dual_plane_status`

## Requirements
- R1: After synchronous reset, rd_data is 0, drive_en is 0, ready is 1 and both toggle bits are cleared.
- R2: While ce_n and oe_n are both low in a cycle, drive_en is 1 after the next clock edge and rd_data holds the word formed from that cycle's inputs. In any cycle where either enable is high, drive_en goes to 0 and rd_data keeps its value.
- R3: With op_state idle (0), or when rd_plane differs from busy_plane in program (1) or erase (2) state, rd_data equals array_data on every bit.
- R4: In program state (1), a read with rd_plane equal to busy_plane returns the inverse of prog_poll_bit on bit 7, the busy toggle on bit 6, 1 on bit 2, and array_data on all other bits.
- R5: In erase state (2), a read of the busy plane returns 0 on bit 7, the busy toggle on bit 6 and the suspend toggle on bit 2.
- R6: In erase-suspended state (3), a read with rd_sector equal to erase_sector returns 1 on bits 7 and 6 and the suspend toggle on bit 2. Any other sector returns array_data.
- R7: In suspend-with-program state (4), a read of the busy (programming) plane returns the inverted prog_poll_bit on bit 7, the busy toggle on bit 6 and the suspend toggle on bit 2. Any other read of the erase sector behaves as in R6, and all remaining reads return array_data.
- R8: Each toggle bit inverts once at the first cycle of a read that reports it, so the first such read after idle shows 1. A read held low for several cycles does not advance it, and reads that return array data or do not report that bit leave it unchanged.
- R9: Any cycle in idle state clears both toggle bits. The next status read after a return to idle starts again from 1.
- R10: ready is 0 one cycle after op_state is program (1), erase (2) or suspend-with-program (4), and 1 otherwise, including erase-suspended (3). Values 5 to 7 count as idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| op_state | input | 3 | 0 idle, 1 program, 2 erase, 3 erase suspended, 4 program during suspend |
| busy_plane | input | 1 | Plane running the current program or erase |
| erase_sector | input | SECT_W | Sector under erase (global index) |
| prog_poll_bit | input | 1 | Bit 7 of the last word loaded for programming |
| rd_plane | input | 1 | Plane of the read address |
| rd_sector | input | SECT_W | Sector of the read address |
| array_data | input | DATA_W | Raw array word at the read address |
| ce_n | input | 1 | Active-low chip enable |
| oe_n | input | 1 | Active-low output enable |
| rd_data | output | DATA_W | Registered word to drive |
| drive_en | output | 1 | Registered output-drive enable |
| ready | output | 1 | Registered ready, low while busy |

## Verification
The bench first targets the toggle corner cases. It holds a read low for several cycles, which would make a design that toggles per clock show a changing bit 6. It starts reads with either enable, and it mixes reads of the idle plane into busy-plane reads, which would make a design that advances on every strobe drift out of step. Suspended reads use a sector match and a mismatch on the same plane, so a design that decodes suspend per plane fails. A return to idle between operations catches toggle state carried over from the previous operation, and the ready checks in the suspend state catch a design that treats a held erase as busy.

// File: rtl/dps_pkg.sv
package dps_pkg;
  // operation state encoding
  localparam logic [2:0] OP_IDLE      = 3'd0;
  localparam logic [2:0] OP_PROG      = 3'd1;
  localparam logic [2:0] OP_ERASE     = 3'd2;
  localparam logic [2:0] OP_SUSP      = 3'd3;
  localparam logic [2:0] OP_SUSP_PROG = 3'd4;

  // status bit positions decoded by host software
  localparam int POLL_BIT = 7;
  localparam int BUSY_BIT = 6;
  localparam int SUSP_BIT = 2;

  // toggle bank layout
  localparam int NUM_TOG  = 2;
  localparam int TOG_BUSY = 0;
  localparam int TOG_SUSP = 1;

  typedef enum logic [2:0] {
    VIEW_TRUE,
    VIEW_PROG,
    VIEW_ERASE,
    VIEW_SUSP_SECT,
    VIEW_SUSP_PROG
  } view_e;
endpackage

// File: rtl/dps_read_strobe.sv
module dps_read_strobe (
  input  logic clk,
  input  logic rst,
  input  logic ce_n,
  input  logic oe_n,
  output logic sel,
  output logic start
);
  logic sel_q;

  assign sel   = ~ce_n & ~oe_n;
  assign start = sel & ~sel_q;

  always_ff @(posedge clk) begin
    if (rst) sel_q <= 1'b0;
    else     sel_q <= sel;
  end
endmodule

// File: rtl/dps_view_decode.sv
module dps_view_decode
  import dps_pkg::*;
#(
  parameter int SECT_W = 6
) (
  input  logic [2:0]          op_state,
  input  logic                busy_plane,
  input  logic [SECT_W-1:0]   erase_sector,
  input  logic                rd_plane,
  input  logic [SECT_W-1:0]   rd_sector,
  output view_e               view,
  output logic [NUM_TOG-1:0]  adv,
  output logic                busy,
  output logic                idle
);
  logic plane_hit;
  logic sect_hit;

  assign plane_hit = (rd_plane == busy_plane);
  assign sect_hit  = (rd_sector == erase_sector);

  always_comb begin
    view = VIEW_TRUE;
    busy = 1'b0;
    idle = 1'b0;
    unique case (op_state)
      OP_PROG: begin
        busy = 1'b1;
        if (plane_hit) view = VIEW_PROG;
      end
      OP_ERASE: begin
        busy = 1'b1;
        if (plane_hit) view = VIEW_ERASE;
      end
      OP_SUSP: begin
        if (sect_hit) view = VIEW_SUSP_SECT;
      end
      OP_SUSP_PROG: begin
        busy = 1'b1;
        if (plane_hit)     view = VIEW_SUSP_PROG;
        else if (sect_hit) view = VIEW_SUSP_SECT;
      end
      default: idle = 1'b1;
    endcase
  end

  // which toggles a read of this view advances
  always_comb begin
    adv = '0;
    unique case (view)
      VIEW_PROG:      adv[TOG_BUSY] = 1'b1;
      VIEW_ERASE:     begin adv[TOG_BUSY] = 1'b1; adv[TOG_SUSP] = 1'b1; end
      VIEW_SUSP_SECT: adv[TOG_SUSP] = 1'b1;
      VIEW_SUSP_PROG: begin adv[TOG_BUSY] = 1'b1; adv[TOG_SUSP] = 1'b1; end
      default:        adv = '0;
    endcase
  end
endmodule

// File: rtl/dps_toggle_bank.sv
module dps_toggle_bank #(
  parameter int N = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         clear,
  input  logic         start,
  input  logic [N-1:0] adv,
  output logic [N-1:0] show
);
  for (genvar i = 0; i < N; i++) begin : g_tog
    logic state;
    // value presented to the current read, already advanced on its first cycle
    assign show[i] = state ^ (start & adv[i]);
    always_ff @(posedge clk) begin
      if (rst || clear) state <= 1'b0;
      else if (start)   state <= show[i];
    end
  end
endmodule

// File: rtl/dps_word_build.sv
module dps_word_build
  import dps_pkg::*;
#(
  parameter int DATA_W = 16
) (
  input  view_e               view,
  input  logic                prog_poll_bit,
  input  logic [NUM_TOG-1:0]  tog,
  input  logic [DATA_W-1:0]   array_data,
  output logic [DATA_W-1:0]   word
);
  always_comb begin
    word = array_data;
    unique case (view)
      VIEW_PROG: begin
        word[POLL_BIT] = ~prog_poll_bit;
        word[BUSY_BIT] = tog[TOG_BUSY];
        word[SUSP_BIT] = 1'b1;
      end
      VIEW_ERASE: begin
        word[POLL_BIT] = 1'b0;
        word[BUSY_BIT] = tog[TOG_BUSY];
        word[SUSP_BIT] = tog[TOG_SUSP];
      end
      VIEW_SUSP_SECT: begin
        word[POLL_BIT] = 1'b1;
        word[BUSY_BIT] = 1'b1;
        word[SUSP_BIT] = tog[TOG_SUSP];
      end
      VIEW_SUSP_PROG: begin
        word[POLL_BIT] = ~prog_poll_bit;
        word[BUSY_BIT] = tog[TOG_BUSY];
        word[SUSP_BIT] = tog[TOG_SUSP];
      end
      default: word = array_data;
    endcase
  end
endmodule

// File: rtl/dual_plane_status.sv
module dual_plane_status
  import dps_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int SECT_W = 6
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [2:0]        op_state,
  input  logic              busy_plane,
  input  logic [SECT_W-1:0] erase_sector,
  input  logic              prog_poll_bit,
  input  logic              rd_plane,
  input  logic [SECT_W-1:0] rd_sector,
  input  logic [DATA_W-1:0] array_data,
  input  logic              ce_n,
  input  logic              oe_n,
  output logic [DATA_W-1:0] rd_data,
  output logic              drive_en,
  output logic              ready
);
  logic               rd_sel;
  logic               rd_start;
  view_e              view;
  logic [NUM_TOG-1:0] adv;
  logic [NUM_TOG-1:0] tog;
  logic               busy_op;
  logic               idle_op;
  logic [DATA_W-1:0]  word;

  dps_read_strobe u_strobe (
    .clk   (clk),
    .rst   (rst),
    .ce_n  (ce_n),
    .oe_n  (oe_n),
    .sel   (rd_sel),
    .start (rd_start)
  );

  dps_view_decode #(.SECT_W(SECT_W)) u_decode (
    .op_state     (op_state),
    .busy_plane   (busy_plane),
    .erase_sector (erase_sector),
    .rd_plane     (rd_plane),
    .rd_sector    (rd_sector),
    .view         (view),
    .adv          (adv),
    .busy         (busy_op),
    .idle         (idle_op)
  );

  dps_toggle_bank #(.N(NUM_TOG)) u_toggle (
    .clk   (clk),
    .rst   (rst),
    .clear (idle_op),
    .start (rd_start),
    .adv   (adv),
    .show  (tog)
  );

  dps_word_build #(.DATA_W(DATA_W)) u_word (
    .view          (view),
    .prog_poll_bit (prog_poll_bit),
    .tog           (tog),
    .array_data    (array_data),
    .word          (word)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_data  <= '0;
      drive_en <= 1'b0;
      ready    <= 1'b1;
    end else begin
      drive_en <= rd_sel;
      ready    <= ~busy_op;
      if (rd_sel) rd_data <= word;
    end
  end
endmodule

// File: rtl/dps_status_checker.sv
module dps_status_checker
  import dps_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int SECT_W = 6
) (
  input logic              clk,
  input logic              rst,
  input logic [2:0]        op_state,
  input logic              busy_plane,
  input logic [SECT_W-1:0] erase_sector,
  input logic              prog_poll_bit,
  input logic              rd_plane,
  input logic [SECT_W-1:0] rd_sector,
  input logic [DATA_W-1:0] array_data,
  input logic              ce_n,
  input logic              oe_n,
  input logic [DATA_W-1:0] rd_data,
  input logic              drive_en,
  input logic              ready
);
  logic sel;
  logic op_busy;
  assign sel     = !ce_n && !oe_n;
  assign op_busy = (op_state == OP_PROG) || (op_state == OP_ERASE) ||
                   (op_state == OP_SUSP_PROG);

  assert_drive_follows_R2: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> drive_en == $past(sel));

  assert_hold_deselected_R2: assert property (@(posedge clk) disable iff (rst)
    !sel |=> $stable(rd_data));

  assert_idle_true_R3: assert property (@(posedge clk) disable iff (rst)
    (sel && op_state == OP_IDLE) |=> rd_data == $past(array_data));

  assert_prog_poll_R4: assert property (@(posedge clk) disable iff (rst)
    (sel && op_state == OP_PROG && rd_plane == busy_plane) |=>
      (rd_data[SUSP_BIT] && rd_data[POLL_BIT] == !$past(prog_poll_bit)));

  assert_erase_poll_R5: assert property (@(posedge clk) disable iff (rst)
    (sel && op_state == OP_ERASE && rd_plane == busy_plane) |=> !rd_data[POLL_BIT]);

  assert_susp_sector_R6: assert property (@(posedge clk) disable iff (rst)
    (sel && op_state == OP_SUSP && rd_sector == erase_sector) |=>
      (rd_data[POLL_BIT] && rd_data[BUSY_BIT]));

  assert_ready_R10: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> ready == !$past(op_busy));
endmodule

bind dual_plane_status dps_status_checker #(.DATA_W(DATA_W), .SECT_W(SECT_W)) u_chk (
  .clk           (clk),
  .rst           (rst),
  .op_state      (op_state),
  .busy_plane    (busy_plane),
  .erase_sector  (erase_sector),
  .prog_poll_bit (prog_poll_bit),
  .rd_plane      (rd_plane),
  .rd_sector     (rd_sector),
  .array_data    (array_data),
  .ce_n          (ce_n),
  .oe_n          (oe_n),
  .rd_data       (rd_data),
  .drive_en      (drive_en),
  .ready         (ready)
);

// File: tb/dual_plane_status_bench.sv
`timescale 1ns/1ps
module dual_plane_status_bench;
  localparam int DATA_W = 16;
  localparam int SECT_W = 6;

  logic              clk = 1'b0;
  logic              rst;
  logic [2:0]        op_state;
  logic              busy_plane;
  logic [SECT_W-1:0] erase_sector;
  logic              prog_poll_bit;
  logic              rd_plane;
  logic [SECT_W-1:0] rd_sector;
  logic [DATA_W-1:0] array_data;
  logic              ce_n;
  logic              oe_n;
  logic [DATA_W-1:0] rd_data;
  logic              drive_en;
  logic              ready;

  int n_cmp = 0;
  int n_bad = 0;
  bit done  = 1'b0;
  logic m_busy_tog = 1'b0;
  logic m_susp_tog = 1'b0;

  always #2.5 clk = ~clk;

  dual_plane_status #(.DATA_W(DATA_W), .SECT_W(SECT_W)) u_dual_plane_status (
    .clk(clk), .rst(rst), .op_state(op_state), .busy_plane(busy_plane),
    .erase_sector(erase_sector), .prog_poll_bit(prog_poll_bit),
    .rd_plane(rd_plane), .rd_sector(rd_sector), .array_data(array_data),
    .ce_n(ce_n), .oe_n(oe_n), .rd_data(rd_data), .drive_en(drive_en),
    .ready(ready)
  );

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // 0 true data, 1 program, 2 erase, 3 suspended sector, 4 suspend+program
  function automatic int view_of(logic [2:0] op, logic bp, logic [SECT_W-1:0] es,
                                 logic rp, logic [SECT_W-1:0] rs);
    case (op)
      3'd1: return (rp == bp) ? 1 : 0;
      3'd2: return (rp == bp) ? 2 : 0;
      3'd3: return (rs == es) ? 3 : 0;
      3'd4: return (rp == bp) ? 4 : ((rs == es) ? 3 : 0);
      default: return 0;
    endcase
  endfunction

  function automatic string req_of(int v);
    case (v)
      1: return "R4";
      2: return "R5";
      3: return "R6";
      4: return "R7";
      default: return "R3";
    endcase
  endfunction

  function automatic logic [DATA_W-1:0] exp_word(int v, logic pb, logic [DATA_W-1:0] arr,
                                                 logic tb6, logic tb2);
    logic [DATA_W-1:0] w = arr;
    case (v)
      1: begin w[7] = ~pb; w[6] = tb6; w[2] = 1'b1; end
      2: begin w[7] = 1'b0; w[6] = tb6; w[2] = tb2; end
      3: begin w[7] = 1'b1; w[6] = 1'b1; w[2] = tb2; end
      4: begin w[7] = ~pb; w[6] = tb6; w[2] = tb2; end
      default: ;
    endcase
    return w;
  endfunction

  // one read: hold extra cycles, release via ce_n or oe_n
  task automatic do_read(logic [2:0] op, logic bp, logic [SECT_W-1:0] es, logic pb,
                         logic rp, logic [SECT_W-1:0] rs, logic [DATA_W-1:0] arr,
                         int hold, bit by_ce);
    int v;
    logic [DATA_W-1:0] e;
    @(negedge clk);
    op_state = op; busy_plane = bp; erase_sector = es; prog_poll_bit = pb;
    rd_plane = rp; rd_sector = rs; array_data = arr;
    ce_n = 1'b0; oe_n = 1'b0;
    v = view_of(op, bp, es, rp, rs);
    if (!(op == 3'd1 || op == 3'd2 || op == 3'd3 || op == 3'd4)) begin
      m_busy_tog = 1'b0; m_susp_tog = 1'b0;  // R9
    end
    if (v == 1 || v == 2 || v == 4) m_busy_tog = ~m_busy_tog;  // R8
    if (v == 2 || v == 3 || v == 4) m_susp_tog = ~m_susp_tog;  // R8
    e = exp_word(v, pb, arr, m_busy_tog, m_susp_tog);
    @(negedge clk);
    check(req_of(v), rd_data, e);
    check("R2", drive_en, 1'b1);
    check("R10", ready, (op == 3'd1 || op == 3'd2 || op == 3'd4) ? 1'b0 : 1'b1);
    for (int i = 0; i < hold; i++) begin
      @(negedge clk);
      check("R8", rd_data, e);
    end
    if (by_ce) ce_n = 1'b1; else oe_n = 1'b1;
    @(negedge clk);
    check("R2", drive_en, 1'b0);
    if (by_ce) oe_n = 1'b1;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    int unsigned seed;
    seed = $urandom(32'd4242);
    rst = 1'b1; op_state = 3'd0; busy_plane = 1'b0; erase_sector = '0;
    prog_poll_bit = 1'b0; rd_plane = 1'b0; rd_sector = '0; array_data = '0;
    ce_n = 1'b1; oe_n = 1'b1;
    repeat (3) @(negedge clk);
    // R1 reset state
    check("R1", rd_data, 16'h0000);
    check("R1", drive_en, 1'b0);
    check("R1", ready, 1'b1);
    rst = 1'b0;

    // R3 idle pass-through
    do_read(3'd0, 1'b0, 6'd3, 1'b0, 1'b0, 6'd3, 16'hBEEF, 0, 1'b0);
    // R4 program, busy plane: first status read shows toggle 1
    do_read(3'd1, 1'b1, 6'd0, 1'b1, 1'b1, 6'd20, 16'h0000, 2, 1'b0);
    do_read(3'd1, 1'b1, 6'd0, 1'b1, 1'b1, 6'd20, 16'h0000, 0, 1'b1);
    // R3 other plane during program, must not advance toggle
    do_read(3'd1, 1'b1, 6'd0, 1'b1, 1'b0, 6'd2, 16'h1234, 0, 1'b0);
    do_read(3'd1, 1'b1, 6'd0, 1'b0, 1'b1, 6'd20, 16'hFFFF, 0, 1'b0);
    // R2 deselected input change keeps rd_data
    begin
      logic [DATA_W-1:0] held;
      held = rd_data;
      @(negedge clk); array_data = 16'h5A5A;
      @(negedge clk);
      check("R2", rd_data, held);
      check("R2", drive_en, 1'b0);
    end
    // R9 idle clears toggles
    do_read(3'd0, 1'b0, 6'd0, 1'b0, 1'b0, 6'd0, 16'h0F0F, 0, 1'b0);
    // R5 erase
    do_read(3'd2, 1'b0, 6'd5, 1'b0, 1'b0, 6'd5, 16'hFFFF, 1, 1'b1);
    do_read(3'd2, 1'b0, 6'd5, 1'b0, 1'b0, 6'd7, 16'hFFFF, 0, 1'b0);
    // R6 suspended: erased sector, neighbour on same plane
    do_read(3'd3, 1'b0, 6'd5, 1'b0, 1'b0, 6'd5, 16'h0000, 0, 1'b0);
    do_read(3'd3, 1'b0, 6'd5, 1'b0, 1'b0, 6'd6, 16'hA5C3, 0, 1'b0);
    // R7 suspend + program in other plane
    do_read(3'd4, 1'b1, 6'd5, 1'b0, 1'b1, 6'd30, 16'h0000, 0, 1'b0);
    do_read(3'd4, 1'b1, 6'd5, 1'b0, 1'b0, 6'd5, 16'h0000, 0, 1'b1);
    do_read(3'd4, 1'b1, 6'd5, 1'b0, 1'b0, 6'd4, 16'h7E81, 0, 1'b0);
    // R10 unused encoding acts as idle
    do_read(3'd6, 1'b1, 6'd5, 1'b0, 1'b1, 6'd5, 16'h3C3C, 0, 1'b0);

    // constrained random phases
    for (int ph = 0; ph < 60; ph++) begin
      logic [2:0] op;
      logic bp;
      logic [SECT_W-1:0] es;
      logic pb;
      op = 3'($urandom_range(0, 4));
      bp = 1'($urandom);
      es = SECT_W'($urandom_range(0, 7));
      pb = 1'($urandom);
      for (int r = 0; r < 12; r++) begin
        do_read(op, bp, es, pb, 1'($urandom), SECT_W'($urandom_range(0, 7)),
                16'($urandom), int'($urandom_range(0, 2)), 1'($urandom));
      end
    end

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule